// File: doc/BRIEF.md
# Reloading Interval Timer Channel

This block is a single timer channel that divides an external count-enable tick into a periodic interrupt pulse. It can also produce a square wave by toggling an output level on each interval. Software programs a period value, picks whether the first tick after a start should signal, and then starts or stops the channel through self-clearing command bits. While it runs, a down-counter steps once per tick. When the counter has reached zero, the next tick reloads the period value, so one interval lasts (period + 1) ticks.

All access goes through one register port that is written in a single cycle and read combinationally. The port carries control and status only, with no streamed data, so it has no valid/ready handshake and never pushes back. A write is taken in the cycle `reg_wr` is high. The tick input is a plain one-cycle enable from a prescaler outside the block.

Register map (3-bit address): 0 = period (16 bits, read/write); 1 = mode (bit 0, first-tick signalling); 2 = command (bit 0 start, bit 1 stop, write-only, reads 0); 3 = output setup (bit 0 level, bit 1 output enable); 4 = counter (read-only); 5 = status (bit 0 running). Unmapped addresses read 0.

Top module: `tmr_interval`

## Requirements
- R1: Writing 1 to command bit 0 while stopped sets status bit 0 (running). Writing 1 to command bit 1 clears it. The command register always reads 0. A start while the channel is already running has no effect on the count.
- R2: The first tick after a start loads the period value into the counter.
- R3: On that first load, mode bit 0 = 1 gives an interrupt pulse and an output toggle. Mode bit 0 = 0 gives neither.
- R4: After the first load, each tick while running lowers the counter by one. Cycles without a tick leave it unchanged.
- R5: A tick that arrives while the counter is 0 reloads the period value, and counting goes on.
- R6: Every reload at zero produces an `irq_pulse` that is high for exactly one cycle, the cycle after the tick. With output enable = 1, the same event inverts `wave_out`.
- R7: The period register can be written at any time. A write does not alter the counter and takes effect at the next reload.
- R8: A write to the mode register while running is ignored, as its readback shows.
- R9: Stop freezes the counter and the output level, and later ticks do nothing. When start and stop are written together, stop wins.
- R10: A write to the level bit takes effect only while output enable is 0. `wave_out` always shows the level bit. With output enable = 0, timer events do not change it.
- R11: After reset the counter is 0, running is 0, the level and output enable are 0, mode is 0, and the period reads FFFFh.
- R12: While running, the interval between interrupt pulses is (period + 1) ticks, including period = 0, which gives a pulse on every tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Combinational read data for `reg_addr` |
| cnt_tick | input | 1 | Count-enable tick from the prescaler |
| irq_pulse | output | 1 | One-cycle interval interrupt |
| wave_out | output | 1 | Square-wave / preset output level |

## Verification
The assertions assume that `cnt_tick` is a clean single-cycle enable and that at most one register write arrives per cycle. They also assume that the command bits are pulses, because the port itself makes them self-clearing. The bench drives all inputs on the falling edge and holds each tick and each write for exactly one cycle. It reads status through the register port at points where no tick is pending. Start and stop are written together only through the command register, which is the one path the stop-wins rule covers.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_PERIOD = 3'd0,
    RA_MODE   = 3'd1,
    RA_CMD    = 3'd2,
    RA_OUT    = 3'd3,
    RA_COUNT  = 3'd4,
    RA_STATUS = 3'd5
  } reg_addr_e;

  localparam int CMD_START_BIT = 0;
  localparam int CMD_STOP_BIT  = 1;
  localparam int OUT_LVL_BIT   = 0;
  localparam int OUT_EN_BIT    = 1;

  typedef struct packed {
    logic start;
    logic stop;
  } cmd_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  wdata,
  input  logic              running,
  input  logic              toggle,
  input  logic [CNT_W-1:0]  count,
  output logic [CNT_W-1:0]  period,
  output logic              mode,
  output logic              oe,
  output logic              level,
  output cmd_t              cmd,
  output logic [CNT_W-1:0]  rdata
);
  localparam logic [CNT_W-1:0] PERIOD_RST = '1;

  logic wr_period, wr_mode, wr_cmd, wr_out;

  assign wr_period = wr && (addr == RA_PERIOD);
  assign wr_mode   = wr && (addr == RA_MODE);
  assign wr_cmd    = wr && (addr == RA_CMD);
  assign wr_out    = wr && (addr == RA_OUT);

  // Trigger bits: live only during the write cycle, never stored
  assign cmd.start = wr_cmd && wdata[CMD_START_BIT];
  assign cmd.stop  = wr_cmd && wdata[CMD_STOP_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      period <= PERIOD_RST;
      mode   <= 1'b0;
      oe     <= 1'b0;
      level  <= 1'b0;
    end else begin
      if (wr_period) period <= wdata;
      if (wr_mode && !running) mode <= wdata[0];
      if (wr_out) oe <= wdata[OUT_EN_BIT];
      if (wr_out && !oe) level <= wdata[OUT_LVL_BIT];
      else if (toggle && oe) level <= ~level;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      RA_PERIOD: rdata = period;
      RA_MODE:   rdata[0] = mode;
      RA_OUT:    begin
        rdata[OUT_LVL_BIT] = level;
        rdata[OUT_EN_BIT]  = oe;
      end
      RA_COUNT:  rdata = count;
      RA_STATUS: rdata[0] = running;
      default:   rdata = '0;
    endcase
  end

  p_mode_locked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (running && wr_mode) |=> $stable(mode));
  p_level_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (oe && !toggle) |=> $stable(level));
  p_level_no_evt_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!oe && !wr_out) |=> $stable(level));
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  cmd_t cmd,
  input  logic tick,
  output logic running,
  output logic first,
  output logic step
);
  logic run_q, first_q;

  assign running = run_q;
  assign first   = first_q;
  assign step    = run_q && tick && !cmd.stop;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (cmd.stop) begin
      run_q   <= 1'b0;
      first_q <= 1'b0;
    end else if (cmd.start && !run_q) begin
      run_q   <= 1'b1;
      first_q <= 1'b1;
    end else if (step && first_q) begin
      first_q <= 1'b0;
    end
  end

  p_stop_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.stop |=> !running);
  p_start_arms_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.start && !cmd.stop && !running) |=> (running && first));
  p_first_clears_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && first) |=> !first);
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             first,
  input  logic             mode,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] count,
  output logic             event_now,
  output logic             irq
);
  logic at_zero, reload;

  assign at_zero   = (count == '0);
  assign reload    = step && (first || at_zero);
  assign event_now = step && (first ? mode : at_zero);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count <= '0;
      irq   <= 1'b0;
    end else begin
      irq <= event_now;
      if (reload) count <= period;
      else if (step) count <= count - 1'b1;
    end
  end

  p_dec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first && !at_zero) |=> (count == CNT_W'($past(count) - 1'b1)));
  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(count));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !first && at_zero) |=> (count == $past(period) && irq));
  p_first_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && first) |=> (count == $past(period)));
  p_first_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && first && !mode) |=> !irq);
  p_irq_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(step));
endmodule

// File: rtl/tmr_interval.sv
module tmr_interval
  import tmr_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic [2:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  input  logic             cnt_tick,
  output logic             irq_pulse,
  output logic             wave_out
);
  cmd_t             cmd;
  logic [CNT_W-1:0] period, count;
  logic             mode, oe, level;
  logic             running, first, step, event_now;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
    .running(running), .toggle(event_now), .count(count),
    .period(period), .mode(mode), .oe(oe), .level(level), .cmd(cmd),
    .rdata(reg_rdata)
  );

  tmr_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(cnt_tick),
    .running(running), .first(first), .step(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .step(step), .first(first), .mode(mode),
    .period(period), .count(count), .event_now(event_now), .irq(irq_pulse)
  );

  assign wave_out = level;

  p_wave_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !reg_wr) |=> $stable(wave_out));
endmodule

// File: tb/tb_tmr_interval.sv
module tb_tmr_interval;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic        cnt_tick = 1'b0;
  logic        irq_pulse;
  logic        wave_out;

  int n_run = 0;
  int n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_interval dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cnt_tick(cnt_tick),
    .irq_pulse(irq_pulse), .wave_out(wave_out)
  );

  task automatic chk(string req, int act, int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output int d);
    @(negedge clk);
    reg_addr = a;
    #1 d = int'(reg_rdata);
  endtask

  task automatic tick(output int irq_seen);
    @(negedge clk);
    cnt_tick = 1'b1;
    @(negedge clk);
    cnt_tick = 1'b0;
    irq_seen = int'(irq_pulse);
  endtask

  task automatic setup(input int per, input int md, input int en, input int lvl);
    wr(3'd2, 16'h0002);
    wr(3'd0, 16'(per));
    wr(3'd1, 16'(md));
    wr(3'd3, 16'(lvl));
    wr(3'd3, 16'(lvl));
    wr(3'd3, 16'((en << 1) | lvl));
  endtask

  task automatic t_reset;
    int v;
    rd(3'd4, v); chk("R11 count", v, 0);
    rd(3'd5, v); chk("R11 running", v, 0);
    rd(3'd0, v); chk("R11 period", v, 16'hFFFF);
    rd(3'd1, v); chk("R11 mode", v, 0);
    rd(3'd3, v); chk("R11 outcfg", v, 0);
    chk("R11 wave", int'(wave_out), 0);
    chk("R11 irq", int'(irq_pulse), 0);
  endtask

  task automatic t_basic_mode0;
    int v, q;
    setup(3, 0, 1, 0);
    wr(3'd2, 16'h0001);
    rd(3'd5, v); chk("R1 running", v, 1);
    rd(3'd2, v); chk("R1 cmd reads 0", v, 0);
    tick(q); rd(3'd4, v);
    chk("R2 first load", v, 3);
    chk("R3 mode0 no irq", q, 0);
    chk("R3 mode0 no toggle", int'(wave_out), 0);
    rd(3'd4, v); chk("R4 no tick hold", v, 3);
    for (int i = 2; i >= 0; i--) begin
      tick(q); rd(3'd4, v);
      chk("R4 decrement", v, i);
      chk("R4 no irq", q, 0);
    end
    tick(q); chk("R6 irq", q, 1);
    chk("R6 toggle", int'(wave_out), 1);
    rd(3'd4, v); chk("R5 reload", v, 3);
    chk("R6 one-cycle irq", int'(irq_pulse), 0);
  endtask

  task automatic t_restart_ignored;
    int v, q;
    setup(3, 0, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q); tick(q);
    wr(3'd2, 16'h0001);
    tick(q); rd(3'd4, v); chk("R1 start while running ignored", v, 1);
  endtask

  task automatic t_mode1;
    int v, q;
    setup(5, 1, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q); rd(3'd4, v);
    chk("R2 load mode1", v, 5);
    chk("R3 mode1 irq", q, 1);
    chk("R3 mode1 toggle", int'(wave_out), 1);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R8 mode locked", v, 1);
    wr(3'd2, 16'h0002);
    wr(3'd1, 16'h0000);
    rd(3'd1, v); chk("R8 mode writable stopped", v, 0);
  endtask

  task automatic t_stop_freeze;
    int v, q, irqs;
    setup(1, 1, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q); tick(q);
    wr(3'd2, 16'h0002);
    rd(3'd5, v); chk("R1 stop clears running", v, 0);
    irqs = 0;
    for (int i = 0; i < 3; i++) begin tick(q); irqs += q; end
    rd(3'd4, v); chk("R9 counter frozen", v, 0);
    chk("R9 level frozen", int'(wave_out), 1);
    chk("R9 no irq stopped", irqs, 0);
  endtask

  task automatic t_start_stop_same;
    int v;
    wr(3'd2, 16'h0003);
    rd(3'd5, v); chk("R9 stop wins idle", v, 0);
    wr(3'd2, 16'h0001);
    wr(3'd2, 16'h0003);
    rd(3'd5, v); chk("R9 stop wins running", v, 0);
  endtask

  task automatic t_period_rewrite;
    int v, q;
    setup(3, 0, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q); tick(q);
    wr(3'd0, 16'd5);
    rd(3'd4, v); chk("R7 count unchanged", v, 2);
    tick(q); tick(q);
    rd(3'd4, v); chk("R7 old countdown", v, 0);
    tick(q); rd(3'd4, v);
    chk("R7 new period at reload", v, 5);
    chk("R7 irq at reload", q, 1);
  endtask

  task automatic t_level_preset;
    int v, q;
    setup(1, 0, 0, 0);
    wr(3'd3, 16'h0001);
    chk("R10 preset with oe0", int'(wave_out), 1);
    wr(3'd2, 16'h0001);
    tick(q); tick(q); tick(q);
    chk("R10 irq with oe0", q, 1);
    chk("R10 no toggle oe0", int'(wave_out), 1);
    wr(3'd3, 16'h0003);
    wr(3'd3, 16'h0002);
    chk("R10 preset ignored oe1", int'(wave_out), 1);
    tick(q); tick(q);
    chk("R10 toggle oe1", int'(wave_out), 0);
  endtask

  task automatic t_interval;
    int q, irqs;
    setup(2, 0, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q);
    irqs = 0;
    for (int i = 0; i < 9; i++) begin tick(q); irqs += q; end
    chk("R12 period2 irqs in 9 ticks", irqs, 3);
    setup(0, 0, 1, 0);
    wr(3'd2, 16'h0001);
    tick(q);
    irqs = 0;
    for (int i = 0; i < 4; i++) begin tick(q); irqs += q; end
    chk("R12 period0 irq every tick", irqs, 4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic_mode0();
    t_restart_ignored();
    t_mode1();
    t_stop_freeze();
    t_start_stop_same();
    t_period_rewrite();
    t_level_preset();
    t_interval();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule